// File: doc/BRIEF.md
# Runtime-Configurable Serial Frame Transmitter

This block turns one data word at a time into an asynchronous serial frame on a single output line. The frame shape is not fixed at build time. Inputs choose how many data bits go out (five to eight), how many clock cycles each bit lasts, whether a parity bit is added and which sense it has, whether one or two stop bits close the frame, and which level the line rests at between frames.

An upstream queue places a word on the data input and pulses the load strobe for one cycle while the busy output is low. The block samples the word and the whole configuration at that edge. From the next cycle it drives a start bit, then the data bits least significant first, then the optional parity bit, then the stop bits. Each bit is held for the programmed number of clocks. The busy output stays high for the whole frame and falls on the edge where the line returns to rest, so the queue can apply the next word in the same cycle.

Top module: `cfg_serial_tx`

## Requirements
- R1: While no frame is in progress, `line_o` equals the live `idle_lvl_i` and `busy_o` is low. This holds after reset and immediately after `rst_ni` is asserted in the middle of a frame.
- R2: The number of data bits sent is `width_i` clamped to the range 5 to 8. Bit 5 is sent only when `width_i` > 5, bit 6 only when `width_i` > 6, and bit 7 only when `width_i` > 7.
- R3: Data bits follow the start bit directly, least significant bit first. Each is driven at its true value, whatever the idle level.
- R4: The start bit drives `line_o` to the inverse of the idle level that was sampled at load.
- R5: When `parity_en_i` is 1 at load, one parity bit is placed after the last data bit and before the first stop bit. When it is 0, no parity bit is sent.
- R6: The parity bit covers only the data bits that are sent. `parity_odd_i` = 0 makes the count of ones in the data and parity bits even; `parity_odd_i` = 1 makes it odd.
- R7: `stop_sel_i` = 2'b10 gives two stop bits and every other value gives one. Each stop bit drives the idle level that was sampled at load.
- R8: Every bit of a frame is held for `bit_period_i` clock cycles. A value of 0 or 1 gives one cycle per bit.
- R9: A load strobe that is sampled while `busy_o` is low is accepted. The start bit appears in the next cycle, and `busy_o` is high for exactly (1 + data bits + parity bits + stop bits) × period cycles.
- R10: A load strobe that is sampled while `busy_o` is high is ignored. This includes a strobe held high for many cycles.
- R11: The data, width, period, parity, stop and idle inputs are captured at load. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Word to transmit |
| load_i | input | 1 | One-cycle strobe that loads a word |
| width_i | input | 4 | Data word width, clamped to 5..8 |
| bit_period_i | input | 16 | Clock cycles per serial bit |
| parity_en_i | input | 1 | Adds a parity bit when 1 |
| parity_odd_i | input | 1 | 0 selects even parity, 1 selects odd parity |
| stop_sel_i | input | 2 | 2'b10 selects two stop bits, any other value selects one |
| idle_lvl_i | input | 1 | Resting level of the line |
| line_o | output | 1 | Serial output line |
| busy_o | output | 1 | High while a frame is being sent |

## Verification
On every cycle the assertions check four things: the baud counter stays below its reload value, the data-bit countdown stays in range, the start and stop bits sit at the levels set by the captured idle level, and the captured configuration and bit position do not move when a strobe arrives during a frame. Some properties can only be shown by the bench's scenarios, which compare each cycle against a queue-based model. These are the exact bit order, the parity value, the clamping of the word width, the stop-bit count, the frame length in cycles, and the fact that mid-frame changes to the inputs have no effect on the frame being sent.

// File: rtl/cfg_serial_tx_pkg.sv
package cfg_serial_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_e;

endpackage

// File: rtl/txf_baud_timer.sv
module txf_baud_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                restart_i,
  input  logic                run_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                tick_o
);

  logic [PERIOD_W-1:0] cnt_q, reload_q, eff_period;

  // 0 and 1 both mean one clock per bit
  assign eff_period = (period_i < PERIOD_W'(2)) ? PERIOD_W'(1) : period_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= PERIOD_W'(1);
    end else if (restart_i) begin
      reload_q <= eff_period;
      cnt_q    <= eff_period - PERIOD_W'(1);
    end else if (run_i) begin
      cnt_q <= (cnt_q == '0) ? reload_q - PERIOD_W'(1) : cnt_q - PERIOD_W'(1);
    end
  end

  assign tick_o = run_i && !restart_i && (cnt_q == '0);

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < reload_q)); // R8
  AST_RELOAD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_q != '0); // R8

endmodule

// File: rtl/txf_parity_gen.sv
module txf_parity_gen #(
  parameter int DATA_W  = 8,
  parameter int WIDTH_W = 4,
  parameter int MIN_W   = 5,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [WIDTH_W-1:0] width_i,
  input  logic               odd_i,
  output logic [CNT_W-1:0]   nbits_o,
  output logic               parity_o
);

  logic [DATA_W-1:0] mask;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (i < MIN_W) begin : g_fixed
      assign mask[i] = 1'b1;
    end else begin : g_sel
      assign mask[i] = (int'(width_i) > i);
    end
  end

  always_comb begin
    if (int'(width_i) < MIN_W)       nbits_o = CNT_W'(MIN_W);
    else if (int'(width_i) > DATA_W) nbits_o = CNT_W'(DATA_W);
    else                             nbits_o = CNT_W'(width_i);
  end

  assign parity_o = (^(data_i & mask)) ^ odd_i;

endmodule

// File: rtl/txf_sequencer.sv
module txf_sequencer
  import cfg_serial_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  nbits_i,
  input  logic              parity_bit_i,
  input  logic              parity_en_i,
  input  logic              two_stop_i,
  input  logic              idle_lvl_i,
  input  logic              load_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              line_o
);

  tx_state_e         state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  bits_left_q;
  logic              par_en_q, par_bit_q, stop_left_q, idle_q, line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      shreg_q     <= '0;
      bits_left_q <= '0;
      par_en_q    <= 1'b0;
      par_bit_q   <= 1'b0;
      stop_left_q <= 1'b0;
      idle_q      <= 1'b1;
      line_q      <= 1'b1;
    end else if (accept_i) begin
      state_q     <= ST_START;
      shreg_q     <= data_i;
      bits_left_q <= nbits_i - CNT_W'(1);
      par_en_q    <= parity_en_i;
      par_bit_q   <= parity_bit_i;
      stop_left_q <= two_stop_i;
      idle_q      <= idle_lvl_i;
      line_q      <= ~idle_lvl_i;
    end else if (tick_i) begin
      unique case (state_q)
        ST_START: begin
          state_q <= ST_DATA;
          line_q  <= shreg_q[0];
          shreg_q <= shreg_q >> 1;
        end
        ST_DATA: begin
          if (bits_left_q == '0) begin
            if (par_en_q) begin
              state_q <= ST_PARITY;
              line_q  <= par_bit_q;
            end else begin
              state_q <= ST_STOP;
              line_q  <= idle_q;
            end
          end else begin
            line_q      <= shreg_q[0];
            shreg_q     <= shreg_q >> 1;
            bits_left_q <= bits_left_q - CNT_W'(1);
          end
        end
        ST_PARITY: begin
          state_q <= ST_STOP;
          line_q  <= idle_q;
        end
        ST_STOP: begin
          if (stop_left_q) stop_left_q <= 1'b0;
          else             state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign line_o = busy_o ? line_q : idle_lvl_i;

  AST_START_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START) |-> (line_o == ~idle_q)); // R4
  AST_STOP_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP) |-> (line_o == idle_q)); // R7
  AST_BITS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> (bits_left_q < CNT_W'(DATA_W))); // R2
  AST_BUSY_LOAD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && load_i && !tick_i) |=> ($stable(state_q) && $stable(bits_left_q) && $stable(shreg_q))); // R10
  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !accept_i) |=> ($stable(idle_q) && $stable(par_en_q) && $stable(par_bit_q))); // R11

endmodule

// File: rtl/cfg_serial_tx.sv
module cfg_serial_tx #(
  parameter int DATA_W   = 8,
  parameter int WIDTH_W  = 4,
  parameter int PERIOD_W = 16,
  parameter int MIN_W    = 5,
  localparam int CNT_W   = $clog2(DATA_W + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DATA_W-1:0]   data_i,
  input  logic                load_i,
  input  logic [WIDTH_W-1:0]  width_i,
  input  logic [PERIOD_W-1:0] bit_period_i,
  input  logic                parity_en_i,
  input  logic                parity_odd_i,
  input  logic [1:0]          stop_sel_i,
  input  logic                idle_lvl_i,
  output logic                line_o,
  output logic                busy_o
);

  logic             accept, tick, parity_bit, busy;
  logic [CNT_W-1:0] nbits;

  assign accept = load_i && !busy;

  txf_parity_gen #(
    .DATA_W (DATA_W),
    .WIDTH_W(WIDTH_W),
    .MIN_W  (MIN_W)
  ) u_parity (
    .data_i  (data_i),
    .width_i (width_i),
    .odd_i   (parity_odd_i),
    .nbits_o (nbits),
    .parity_o(parity_bit)
  );

  txf_baud_timer #(
    .PERIOD_W(PERIOD_W)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(accept),
    .run_i    (busy),
    .period_i (bit_period_i),
    .tick_o   (tick)
  );

  txf_sequencer #(
    .DATA_W(DATA_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .data_i      (data_i),
    .nbits_i     (nbits),
    .parity_bit_i(parity_bit),
    .parity_en_i (parity_en_i),
    .two_stop_i  (stop_sel_i == 2'b10),
    .idle_lvl_i  (idle_lvl_i),
    .load_i      (load_i),
    .tick_i      (tick),
    .busy_o      (busy),
    .line_o      (line_o)
  );

  assign busy_o = busy;

  AST_IDLE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (line_o == idle_lvl_i)); // R1
  AST_ACCEPT_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy_o) |=> busy_o); // R9

endmodule

// File: tb/cfg_serial_tx_tb_top.sv
module cfg_serial_tx_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  data_i = '0;
  logic        load_i = 1'b0;
  logic [3:0]  width_i = 4'd8;
  logic [15:0] bit_period_i = 16'd4;
  logic        parity_en_i = 1'b0;
  logic        parity_odd_i = 1'b0;
  logic [1:0]  stop_sel_i = 2'b01;
  logic        idle_lvl_i = 1'b1;
  logic        line_o, busy_o;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1 reset";
  logic  exp_q[$];

  always #4 clk_i = ~clk_i; // 125 MHz

  cfg_serial_tx dut_i (
    .clk_i, .rst_ni, .data_i, .load_i, .width_i, .bit_period_i,
    .parity_en_i, .parity_odd_i, .stop_sel_i, .idle_lvl_i, .line_o, .busy_o
  );

  // reference frame builder
  function automatic void push_frame();
    int nb, per, ns;
    logic par;
    nb  = (width_i > 4'd7) ? 8 : (width_i > 4'd6) ? 7 : (width_i > 4'd5) ? 6 : 5;
    per = (bit_period_i < 16'd2) ? 1 : int'(bit_period_i);
    ns  = (stop_sel_i == 2'b10) ? 2 : 1;
    par = parity_odd_i;
    for (int i = 0; i < nb; i++) par = par ^ data_i[i];
    for (int c = 0; c < per; c++) exp_q.push_back(~idle_lvl_i);
    for (int b = 0; b < nb; b++)
      for (int c = 0; c < per; c++) exp_q.push_back(data_i[b]);
    if (parity_en_i)
      for (int c = 0; c < per; c++) exp_q.push_back(par);
    for (int s = 0; s < ns; s++)
      for (int c = 0; c < per; c++) exp_q.push_back(idle_lvl_i);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exp_q.delete();
    else if (exp_q.size() == 0) begin
      if (load_i) push_frame();
    end else void'(exp_q.pop_front());
  end

  always @(posedge clk_i) begin
    logic el, eb;
    #2;
    el = (exp_q.size() > 0) ? exp_q[0] : idle_lvl_i;
    eb = (exp_q.size() > 0);
    n_cmp++;
    if (line_o !== el || busy_o !== eb) begin
      n_bad++;
      $display("FAIL %s t=%0t line_o=%b busy_o=%b expected line=%b busy=%b",
               cur_req, $time, line_o, busy_o, el, eb);
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
      summary();
    end
  end

  task automatic cfg(input logic [3:0] w, input logic [15:0] p, input logic pe,
                     input logic po, input logic [1:0] st, input logic idl);
    @(negedge clk_i);
    width_i = w; bit_period_i = p; parity_en_i = pe;
    parity_odd_i = po; stop_sel_i = st; idle_lvl_i = idl;
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk_i);
    data_i = d; load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic wait_done();
    while (exp_q.size() != 0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    cur_req = "R3 R9 8-bit no parity";
    cfg(4'd8, 16'd4, 1'b0, 1'b0, 2'b01, 1'b1);
    send(8'hA5); wait_done();
    send(8'h3C); wait_done();

    cur_req = "R2 width clamp low";
    cfg(4'd3, 16'd1, 1'b0, 1'b0, 2'b01, 1'b1);
    send(8'hFF); wait_done();
    cur_req = "R2 width 6";
    cfg(4'd6, 16'd2, 1'b0, 1'b0, 2'b01, 1'b1);
    send(8'hE7); wait_done();
    cur_req = "R2 width 15 clamp high";
    cfg(4'd15, 16'd2, 1'b0, 1'b0, 2'b01, 1'b1);
    send(8'h81); wait_done();

    cur_req = "R5 R6 even parity width 7";
    cfg(4'd7, 16'd3, 1'b1, 1'b0, 2'b01, 1'b1);
    send(8'hC1); wait_done();
    cur_req = "R6 odd parity masked bit7";
    cfg(4'd5, 16'd3, 1'b1, 1'b1, 2'b01, 1'b1);
    send(8'hE3); wait_done();
    cur_req = "R6 odd parity width 8";
    cfg(4'd8, 16'd2, 1'b1, 1'b1, 2'b01, 1'b1);
    send(8'h00); wait_done();

    cur_req = "R7 two stop bits";
    cfg(4'd8, 16'd3, 1'b1, 1'b0, 2'b10, 1'b1);
    send(8'h5A); wait_done();
    cur_req = "R7 stop field 11 one stop";
    cfg(4'd8, 16'd3, 1'b0, 1'b0, 2'b11, 1'b1);
    send(8'h96); wait_done();

    cur_req = "R4 R3 idle low polarity";
    cfg(4'd8, 16'd4, 1'b1, 1'b1, 2'b10, 1'b0);
    send(8'h6D); wait_done();

    cur_req = "R8 period zero";
    cfg(4'd8, 16'd0, 1'b0, 1'b0, 2'b01, 1'b1);
    send(8'hB4); wait_done();
    cur_req = "R8 period 7";
    cfg(4'd6, 16'd7, 1'b1, 1'b0, 2'b01, 1'b1);
    send(8'h2B); wait_done();

    cur_req = "R10 load during busy";
    cfg(4'd8, 16'd3, 1'b0, 1'b0, 2'b01, 1'b1);
    send(8'h71);
    repeat (4) @(negedge clk_i);
    data_i = 8'h0F; load_i = 1'b1;
    @(negedge clk_i); load_i = 1'b0;
    repeat (5) @(negedge clk_i);
    data_i = 8'hF0; load_i = 1'b1;
    repeat (6) @(negedge clk_i);
    load_i = 1'b0;
    wait_done();

    cur_req = "R11 config change mid-frame";
    cfg(4'd8, 16'd3, 1'b1, 1'b0, 2'b10, 1'b1);
    send(8'hC9);
    repeat (5) @(negedge clk_i);
    data_i = 8'h12; width_i = 4'd5; bit_period_i = 16'd9;
    parity_en_i = 1'b0; parity_odd_i = 1'b1; stop_sel_i = 2'b01;
    repeat (20) @(negedge clk_i);
    idle_lvl_i = 1'b0;
    wait_done();
    idle_lvl_i = 1'b1;

    cur_req = "R9 back-to-back held strobe";
    cfg(4'd5, 16'd1, 1'b1, 1'b0, 2'b01, 1'b1);
    @(negedge clk_i);
    data_i = 8'h1D; load_i = 1'b1;
    repeat (30) @(negedge clk_i);
    load_i = 1'b0;
    wait_done();

    cur_req = "R1 reset mid-frame";
    cfg(4'd8, 16'd5, 1'b0, 1'b0, 2'b01, 1'b1);
    send(8'hAA);
    repeat (7) @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    cur_req = "R1 R9 frame after reset";
    send(8'h55); wait_done();

    summary();
  end

endmodule